// File: doc/BRIEF.md
# Cache Range Maintenance Chunker

This block accepts one cache maintenance request at a time: a byte range given by a start address and an exclusive end address, plus an operation (invalidate, clean or flush). It converts the request into a sequence of commands for a downstream line-range maintenance engine. Each command carries an inclusive, line-aligned first and last line address. Lines only partly covered by an invalidate request are cleaned and invalidated one by one, so that bytes outside the range are never lost. The fully covered middle of the range is cut into chunks. No chunk exceeds a configurable byte limit, and no chunk runs past a 4 KiB page boundary.

Commands go out strictly one at a time. A command is held on the command port until the engine acknowledges it with `cmd_done`. After the last acknowledgement, the unit raises `done` for one cycle and becomes ready for the next request. A write-through override input, sampled with the request, removes clean work that a write-through cache never needs.

Top module: `lrc_chunker`

## Requirements
- R1: After synchronous reset, `req_ready` is 1, and `cmd_valid` and `done` are 0.
- R2: Each range command starts at the current line-aligned position `p`. Its inclusive last address equals `L - 32`, where `L` is the smallest of three values: the aligned stop address, `p + 1024`, and the first 4 KiB boundary above `p`. The next chunk starts at `L`.
- R3: The first and last address of every command lie in the same 4 KiB page, and both are aligned to 32 bytes.
- R4: For invalidate (`req_op` = 0) with a start that is not line aligned, the first command is a single-line clean-and-invalidate (`cmd_kind` = 0) on the line that holds the start. Range chunking then begins at the next line boundary.
- R5: For invalidate with an end that is not line aligned, a single-line clean-and-invalidate on the line that holds the end follows any head command. Range chunking then stops at that line's base. If start and end fall inside the same line, only one single-line command is issued.
- R6: For clean (`req_op` = 1) and flush (`req_op` = 2), the start is rounded down and the end is rounded up to line boundaries. Clean issues clean-range commands (`cmd_kind` = 1).
- R7: For flush without override, each chunk gets a clean-range command and then an invalidate-range command (`cmd_kind` = 2) on the same addresses, before the next chunk starts.
- R8: With `wt_override` = 1, a clean request issues no command. A flush request issues only invalidate-range commands.
- R9: `cmd_valid`, `cmd_kind`, `cmd_start` and `cmd_end` stay stable until `cmd_done` is seen. Only one command is outstanding at a time.
- R10: A request with start >= end, or with reserved `req_op` = 3, issues no command and pulses `done` in the cycle after acceptance. Otherwise `done` pulses for one cycle after the last command is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle; request accepted when both high |
| req_op | input | 2 | 0 invalidate, 1 clean, 2 flush, 3 reserved |
| req_start | input | 32 | First byte address |
| req_end | input | 32 | Exclusive end byte address |
| wt_override | input | 1 | Write-through override, sampled at acceptance |
| cmd_valid | output | 1 | Command presented to engine |
| cmd_kind | output | 2 | 0 line clean-invalidate, 1 clean range, 2 invalidate range |
| cmd_start | output | 32 | Inclusive first line address |
| cmd_end | output | 32 | Inclusive last line address |
| cmd_done | input | 1 | Engine acknowledges the current command |
| done | output | 1 | One-cycle request completion pulse |

## Verification
The bench targets ranges that straddle a page boundary, ranges exactly equal to the size cap, and invalidates whose two partial edges fall in one line. A wrong limit would emit a chunk that crosses a page or overruns the cap. A missing same-line check would clean-invalidate the same line twice. It also targets flush under write-through override and empty or reserved requests. Here a faulty design would leak clean commands, or hang waiting for an acknowledgement that never comes. Random engine latency exposes commands that change or advance before `cmd_done`.

// File: rtl/lrc_pkg.sv
package lrc_pkg;
    localparam int unsigned LRC_AW = 32;

    typedef enum logic [1:0] {
        OP_INV   = 2'd0,
        OP_CLEAN = 2'd1,
        OP_FLUSH = 2'd2,
        OP_RSVD  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        K_LINE_CI   = 2'd0,
        K_CLEAN_RNG = 2'd1,
        K_INV_RNG   = 2'd2,
        K_NONE      = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        S_IDLE, S_HEAD, S_TAIL, S_CH_A, S_CH_B, S_FIN
    } state_e;

    typedef struct packed {
        logic              empty;
        logic              head_pend;
        logic [LRC_AW-1:0] head_addr;
        logic              tail_pend;
        logic [LRC_AW-1:0] tail_addr;
        logic [LRC_AW:0]   cur;
        logic [LRC_AW:0]   stop;
    } plan_t;

    function automatic logic [LRC_AW:0] min2(input logic [LRC_AW:0] a,
                                             input logic [LRC_AW:0] b);
        return (a < b) ? a : b;
    endfunction
endpackage

// File: rtl/lrc_align.sv
module lrc_align
    import lrc_pkg::*;
#(
    parameter int unsigned LINE_BYTES = 32
) (
    input  op_e               op,
    input  logic              wt,
    input  logic [LRC_AW-1:0] start_a,
    input  logic [LRC_AW-1:0] end_a,
    output plan_t             plan
);
    localparam int unsigned LSB = $clog2(LINE_BYTES);
    localparam logic [LRC_AW:0] LINE_W = (LRC_AW+1)'(LINE_BYTES);

    logic              head_mis, tail_mis, same_line, raw_empty;
    logic [LRC_AW:0]   s_dn, s_up, e_dn, e_up;

    always_comb begin
        head_mis  = |start_a[LSB-1:0];
        tail_mis  = |end_a[LSB-1:0];
        same_line = (start_a[LRC_AW-1:LSB] == end_a[LRC_AW-1:LSB]);
        raw_empty = (start_a >= end_a);
        s_dn = {1'b0, start_a[LRC_AW-1:LSB], {LSB{1'b0}}};
        e_dn = {1'b0, end_a[LRC_AW-1:LSB], {LSB{1'b0}}};
        s_up = head_mis ? s_dn + LINE_W : s_dn;
        e_up = tail_mis ? e_dn + LINE_W : e_dn;

        plan = '0;
        plan.head_addr = s_dn[LRC_AW-1:0];
        plan.tail_addr = e_dn[LRC_AW-1:0];
        plan.empty = raw_empty || (op == OP_RSVD) || (op == OP_CLEAN && wt);
        if (op == OP_INV) begin
            plan.cur       = s_up;
            plan.stop      = e_dn;
            plan.head_pend = head_mis;
            plan.tail_pend = tail_mis && !(head_mis && same_line);
        end else begin
            plan.cur  = s_dn;
            plan.stop = e_up;
        end
        if (plan.empty) begin
            plan.head_pend = 1'b0;
            plan.tail_pend = 1'b0;
        end
    end
endmodule

// File: rtl/lrc_limit.sv
module lrc_limit
    import lrc_pkg::*;
#(
    parameter int unsigned MAX_BYTES  = 1024,
    parameter int unsigned PAGE_BYTES = 4096
) (
    input  logic [LRC_AW:0] cur,
    input  logic [LRC_AW:0] stop,
    output logic [LRC_AW:0] lim
);
    localparam logic [LRC_AW:0] MAX_W  = (LRC_AW+1)'(MAX_BYTES);
    localparam logic [LRC_AW:0] PMASK  = (LRC_AW+1)'(PAGE_BYTES - 1);
    localparam logic [LRC_AW:0] ONE_W  = (LRC_AW+1)'(1);

    logic [LRC_AW:0] cap, page_nx;

    always_comb begin
        cap     = cur + MAX_W;
        page_nx = (cur | PMASK) + ONE_W;
        lim     = min2(min2(stop, cap), page_nx);
    end
endmodule

// File: rtl/lrc_chunker.sv
module lrc_chunker
    import lrc_pkg::*;
#(
    parameter int unsigned LINE_BYTES = 32,
    parameter int unsigned MAX_BYTES  = 1024,
    parameter int unsigned PAGE_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [LRC_AW-1:0] req_start,
    input  logic [LRC_AW-1:0] req_end,
    input  logic              wt_override,
    output logic              cmd_valid,
    output logic [1:0]        cmd_kind,
    output logic [LRC_AW-1:0] cmd_start,
    output logic [LRC_AW-1:0] cmd_end,
    input  logic              cmd_done,
    output logic              done
);
    localparam logic [LRC_AW:0] LINE_W = (LRC_AW+1)'(LINE_BYTES);

    state_e            state_q, state_d;
    op_e               op_q;
    logic              wt_q;
    logic              tail_pend_q;
    logic [LRC_AW-1:0] head_addr_q, tail_addr_q;
    logic [LRC_AW:0]   cur_q, stop_q, lim, lim_last;
    plan_t             plan;
    logic              accept, split, has_mid, ack;
    kind_e             kind_c;

    lrc_align #(.LINE_BYTES(LINE_BYTES)) u_align (
        .op      (op_e'(req_op)),
        .wt      (wt_override),
        .start_a (req_start),
        .end_a   (req_end),
        .plan    (plan)
    );

    lrc_limit #(.MAX_BYTES(MAX_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_limit (
        .cur  (cur_q),
        .stop (stop_q),
        .lim  (lim)
    );

    always_comb begin
        accept   = req_valid && (state_q == S_IDLE);
        split    = (op_q == OP_FLUSH) && !wt_q;
        has_mid  = cur_q < stop_q;
        ack      = cmd_valid && cmd_done;
        lim_last = lim - LINE_W;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (accept) begin
                if (plan.empty)                 state_d = S_FIN;
                else if (plan.head_pend)        state_d = S_HEAD;
                else if (plan.tail_pend)        state_d = S_TAIL;
                else if (plan.cur < plan.stop)  state_d = S_CH_A;
                else                            state_d = S_FIN;
            end
            S_HEAD: if (ack) begin
                if (tail_pend_q)  state_d = S_TAIL;
                else if (has_mid) state_d = S_CH_A;
                else              state_d = S_FIN;
            end
            S_TAIL: if (ack) state_d = has_mid ? S_CH_A : S_FIN;
            S_CH_A: if (ack) begin
                if (split)             state_d = S_CH_B;
                else if (lim < stop_q) state_d = S_CH_A;
                else                   state_d = S_FIN;
            end
            S_CH_B: if (ack) state_d = (lim < stop_q) ? S_CH_A : S_FIN;
            S_FIN:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= S_IDLE;
            op_q        <= OP_INV;
            wt_q        <= 1'b0;
            tail_pend_q <= 1'b0;
            head_addr_q <= '0;
            tail_addr_q <= '0;
            cur_q       <= '0;
            stop_q      <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                op_q        <= op_e'(req_op);
                wt_q        <= wt_override;
                tail_pend_q <= plan.tail_pend;
                head_addr_q <= plan.head_addr;
                tail_addr_q <= plan.tail_addr;
                cur_q       <= plan.cur;
                stop_q      <= plan.stop;
            end else if (ack && ((state_q == S_CH_A && !split) || state_q == S_CH_B)) begin
                cur_q <= lim;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            S_HEAD, S_TAIL: kind_c = K_LINE_CI;
            S_CH_A:         kind_c = (op_q == OP_CLEAN || split) ? K_CLEAN_RNG : K_INV_RNG;
            S_CH_B:         kind_c = K_INV_RNG;
            default:        kind_c = K_NONE;
        endcase
    end

    always_comb begin
        req_ready = (state_q == S_IDLE);
        done      = (state_q == S_FIN);
        cmd_valid = (kind_c != K_NONE);
        cmd_kind  = kind_c;
        unique case (state_q)
            S_HEAD: begin
                cmd_start = head_addr_q;
                cmd_end   = head_addr_q;
            end
            S_TAIL: begin
                cmd_start = tail_addr_q;
                cmd_end   = tail_addr_q;
            end
            S_CH_A, S_CH_B: begin
                cmd_start = cur_q[LRC_AW-1:0];
                cmd_end   = lim_last[LRC_AW-1:0];
            end
            default: begin
                cmd_start = '0;
                cmd_end   = '0;
            end
        endcase
    end
endmodule

// File: rtl/lrc_chunker_chk.sv
module lrc_chunker_chk
    import lrc_pkg::*;
#(
    parameter int unsigned LINE_BYTES = 32,
    parameter int unsigned MAX_BYTES  = 1024,
    parameter int unsigned PAGE_BYTES = 4096
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              cmd_valid,
    input logic [1:0]        cmd_kind,
    input logic [LRC_AW-1:0] cmd_start,
    input logic [LRC_AW-1:0] cmd_end,
    input logic              cmd_done,
    input logic              done
);
    localparam int unsigned LSB  = $clog2(LINE_BYTES);
    localparam int unsigned PLSB = $clog2(PAGE_BYTES);

    assert_reset_idle_R1: assert property (@(posedge clk)
        $past(rst) |-> (req_ready && !cmd_valid && !done));

    assert_chunk_cap_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_end >= cmd_start &&
                       (cmd_end - cmd_start) < LRC_AW'(MAX_BYTES)));

    assert_same_page_R3: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_start[LRC_AW-1:PLSB] == cmd_end[LRC_AW-1:PLSB] &&
                       cmd_start[LSB-1:0] == '0 && cmd_end[LSB-1:0] == '0));

    assert_line_single_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind == 2'd0) |-> (cmd_start == cmd_end));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd_kind) &&
                                      $stable(cmd_start) && $stable(cmd_end)));

    assert_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        !(cmd_valid && (req_ready || done)));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && req_ready));
endmodule

bind lrc_chunker lrc_chunker_chk #(
    .LINE_BYTES(LINE_BYTES), .MAX_BYTES(MAX_BYTES), .PAGE_BYTES(PAGE_BYTES)
) u_chk (
    .clk(clk), .rst(rst), .req_ready(req_ready), .cmd_valid(cmd_valid),
    .cmd_kind(cmd_kind), .cmd_start(cmd_start), .cmd_end(cmd_end),
    .cmd_done(cmd_done), .done(done)
);

// File: tb/lrc_chunker_tb.sv
module lrc_chunker_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [31:0] req_start = '0;
    logic [31:0] req_end = '0;
    logic        wt_override = 1'b0;
    logic        cmd_valid;
    logic [1:0]  cmd_kind;
    logic [31:0] cmd_start;
    logic [31:0] cmd_end;
    logic        cmd_done = 1'b0;
    logic        done;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;

    int     n_exp;
    int     e_kind [64];
    longint e_s    [64];
    longint e_e    [64];
    string  e_req  [64];

    always #2.5 clk = ~clk;

    lrc_chunker u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_start(req_start), .req_end(req_end),
        .wt_override(wt_override), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_start(cmd_start), .cmd_end(cmd_end), .cmd_done(cmd_done), .done(done)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic add(input int k, input longint s, input longint e, input string req);
        if (n_exp < 64) begin
            e_kind[n_exp] = k; e_s[n_exp] = s; e_e[n_exp] = e; e_req[n_exp] = req;
        end
        n_exp++;
    endtask

    function automatic longint lim_of(input longint p, input longint stop);
        longint l = stop;
        if (p + 1024 < l) l = p + 1024;
        if ((p | 4095) + 1 < l) l = (p | 4095) + 1;
        return l;
    endfunction

    task automatic build(input int op, input longint s, input longint e, input bit wt);
        longint p, stop, l;
        bit head;
        n_exp = 0;
        if (s >= e || op == 3) return;
        if (op == 0) begin
            head = (s % 32) != 0;
            if (head) add(0, s & ~64'd31, s & ~64'd31, "R4");
            if ((e % 32) != 0 && !(head && (s / 32) == (e / 32)))
                add(0, e & ~64'd31, e & ~64'd31, "R5");
            p = (s + 31) & ~64'd31;
            stop = e & ~64'd31;
        end else begin
            if (op == 1 && wt) return;
            p = s & ~64'd31;
            stop = (e + 31) & ~64'd31;
        end
        while (p < stop) begin
            l = lim_of(p, stop);
            if (op == 0) add(2, p, l - 32, "R2");
            else if (op == 1) add(1, p, l - 32, "R6");
            else begin
                if (!wt) add(1, p, l - 32, "R7");
                add(2, p, l - 32, wt ? "R8" : "R7");
            end
            p = l;
        end
    endtask

    task automatic run_req(input int op, input longint s, input longint e, input bit wt);
        int idx = 0;
        int guard = 0;
        bit fin = 0;
        build(op, s, e, wt);
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'(op); req_start = 32'(s);
        req_end = 32'(e); wt_override = wt;
        @(negedge clk);
        req_valid = 1'b0;
        while (!fin && guard < 3000) begin
            guard++;
            if (done) begin
                chk(idx == n_exp, "R10 command count at done", idx, n_exp);
                fin = 1;
            end else if (cmd_valid) begin
                if (idx < n_exp && idx < 64) begin
                    chk(cmd_kind == 2'(e_kind[idx]), e_req[idx], cmd_kind, e_kind[idx]);
                    chk(cmd_start == 32'(e_s[idx]), e_req[idx], cmd_start, e_s[idx]);
                    chk(cmd_end == 32'(e_e[idx]), e_req[idx], cmd_end, e_e[idx]);
                end else begin
                    chk(1'b0, "R8 unexpected command", cmd_kind, -1);
                end
                chk(cmd_start[31:12] == cmd_end[31:12], "R3 page", cmd_end, cmd_start);
                idx++;
                repeat ($urandom % 3) begin
                    @(negedge clk);
                    chk(cmd_valid && cmd_start == 32'(e_s[(idx-1) % 64]) &&
                        cmd_end == 32'(e_e[(idx-1) % 64]), "R9 hold", cmd_start, e_s[(idx-1) % 64]);
                end
                cmd_done = 1'b1;
                @(negedge clk);
                cmd_done = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
        if (!fin) chk(1'b0, "R10 no done", idx, n_exp);
        chk(req_ready == 1'b0 || fin, "R10 ready", req_ready, 1);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                mismatched++;
                compared++;
                $display("FAIL watchdog actual=%0d expected=<150000", cycles);
                $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
                $finish;
            end
        end
    end

    initial begin : main
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
        chk(cmd_valid == 1'b0, "R1 cmd_valid", cmd_valid, 0);
        chk(done == 1'b0, "R1 done", done, 0);

        run_req(0, 64'h100, 64'h100, 0);      // R10 empty
        run_req(3, 64'h100, 64'h400, 0);      // R10 reserved op
        run_req(0, 64'h110, 64'h118, 0);      // R5 same line
        run_req(0, 64'h110, 64'h130, 0);      // R4 R5 adjacent lines
        run_req(0, 64'h0F10, 64'h1208, 0);    // R4 R5 page crossing
        run_req(0, 64'h0, 64'h400, 0);        // R2 exact cap
        run_req(1, 64'h0FF0, 64'h1010, 0);    // R6 rounding across page
        run_req(1, 64'h0, 64'h2000, 1);       // R8 clean skipped
        run_req(2, 64'h0C00, 64'h1800, 0);    // R7 flush pairs
        run_req(2, 64'h0C00, 64'h1800, 1);    // R8 flush invalidate only
        run_req(2, 64'h3, 64'h4, 0);          // R6 one-line flush

        for (int i = 0; i < 300; i++) begin
            longint s = longint'($urandom % 16384);
            longint e = s + longint'($urandom % 3000);
            run_req(int'($urandom % 3), s, e, ($urandom % 4) == 0);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule